// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Engine

This block is a two-stage pipelined multiply-accumulate unit for filter and convolution kernels. Each cycle it can take two signed 16-bit operands, multiply them and add the product into a 40-bit accumulator. The accumulator's guard bits leave room for long filter runs. When the accumulator would leave its range, it clamps at the largest positive or most negative value instead of wrapping. A symmetric mode serves linear-phase FIR filters: it adds the mirrored sample to operand A before the multiply, so one product covers two taps.

A narrower 32-bit result is taken from the accumulator by clamping it to the signed 32-bit range. A sticky flag records that a value left that range. A clear qualifier on an issued operation starts a new sum. The accumulator is then loaded with that operation's product, and the sticky flag restarts from the state of the loaded value. Software needs no range checks between taps.

Top module: `sat_mac`

## Requirements
- R1: While rst_ni is low, acc_o, res_o and ovf_o are all zero.
- R2: An operation issued with valid_i high at clock edge k is visible on acc_o after edge k+1. A new operation may be issued at every edge, and each one uses the accumulator produced by the operation before it, with no stall.
- R3: With sym_i low, an issued operation adds the signed product a_i*b_i (two's complement) to the accumulator.
- R4: With sym_i high, the operand is the 17-bit signed sum a_i+m_i, so the added term is (a_i+m_i)*b_i. The pre-add never wraps, for example a_i=m_i=32767.
- R5: An issued operation with clear_i high loads the accumulator with its own product instead of adding it.
- R6: If an add would exceed the signed 40-bit range, acc_o holds at 2^39-1 (overflow upward) or at -2^39 (overflow downward).
- R7: res_o equals acc_o when acc_o lies in [-2^31, 2^31-1]. Otherwise res_o is 2^31-1 for a positive acc_o and -2^31 for a negative one.
- R8: ovf_o rises when an update leaves the accumulator outside the signed 32-bit range. It stays high through later adds. Only an issued clear resets it, and that clear sets it again at once if the loaded product is itself outside the 32-bit range.
- R9: With valid_i low, clear_i, sym_i and all operands are ignored, and acc_o and ovf_o hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| clear_i | input | 1 | Load instead of accumulate (qualified by valid_i) |
| sym_i | input | 1 | Symmetric mode: pre-add m_i to a_i |
| a_i | input | 16 | Signed sample operand |
| b_i | input | 16 | Signed coefficient operand |
| m_i | input | 16 | Signed mirrored sample |
| acc_o | output | 40 | Accumulator |
| res_o | output | 32 | Accumulator clamped to signed 32 bits |
| ovf_o | output | 1 | Sticky out-of-range flag |

## Verification
A wrong product or a wrong pre-add width shows up on acc_o two edges after the operation is issued. Because each sum builds on the previous one, the error then persists in every later value until the next clear. A lost sticky bit, or a wrap in place of a clamp, appears only after a long run of large products. For that reason directed runs of several hundred maximal symmetric products push the accumulator into both rails, and the bench then watches that acc_o stays pinned there and that ovf_o holds after the sum comes back into range.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned ACC_W = 40;
  localparam int unsigned RES_W = 32;
endpackage

// File: rtl/mac_premul.sv
module mac_premul #(
  parameter int unsigned OP_W = sat_mac_pkg::OP_W,
  localparam int unsigned PRE_W  = OP_W + 1,
  localparam int unsigned PROD_W = 2 * OP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              clear_i,
  input  logic              sym_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic [OP_W-1:0]   m_i,
  output logic              vld_o,
  output logic              clr_o,
  output logic [PROD_W-1:0] prod_o
);
  logic [PRE_W-1:0]  pre;
  logic [PROD_W-1:0] pre_x, b_x, prod_c;

  always_comb begin
    pre = {a_i[OP_W-1], a_i};
    if (sym_i) pre = pre + {m_i[OP_W-1], m_i};
    pre_x  = {{(PROD_W-PRE_W){pre[PRE_W-1]}}, pre};
    b_x    = {{(PROD_W-OP_W){b_i[OP_W-1]}}, b_i};
    // low PROD_W bits of the product are exact for two's complement
    prod_c = pre_x * b_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      clr_o  <= 1'b0;
      prod_o <= '0;
    end else begin
      vld_o <= valid_i;
      clr_o <= valid_i & clear_i;
      if (valid_i) prod_o <= prod_c;
    end
  end

  assert_issue_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> vld_o);
  assert_clear_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && clear_i) |=> clr_o);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!vld_o && !clr_o));
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int unsigned ACC_W  = sat_mac_pkg::ACC_W,
  parameter int unsigned RES_W  = sat_mac_pkg::RES_W,
  parameter int unsigned PROD_W = 2 * sat_mac_pkg::OP_W + 1,
  localparam int unsigned SUM_W = ACC_W + 1,
  localparam int unsigned HI_W  = ACC_W - RES_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              clr_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              ovf_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [SUM_W-1:0] base, addend, sum;
  logic [ACC_W-1:0] acc_nxt;
  logic [HI_W-1:0]  hi_nxt, hi_q;
  logic             out_rng;

  always_comb begin
    addend = {{(SUM_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
    base   = clr_i ? '0 : {acc_o[ACC_W-1], acc_o};
    sum    = base + addend;
    if (sum[SUM_W-1] != sum[SUM_W-2]) acc_nxt = sum[SUM_W-1] ? ACC_MIN : ACC_MAX;
    else                              acc_nxt = sum[ACC_W-1:0];
    hi_nxt  = acc_nxt[ACC_W-1:RES_W-1];
    out_rng = !((hi_nxt == '0) || (hi_nxt == '1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (vld_i) begin
      acc_o <= acc_nxt;
      ovf_o <= (ovf_o & ~clr_i) | out_rng;
    end
  end

  assign hi_q = acc_o[ACC_W-1:RES_W-1];

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(acc_o) && $stable(ovf_o)));
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(vld_i && clr_i)) |=> ovf_o);
  assert_flag_covers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o |-> ((hi_q == '0) || (hi_q == '1)));
  assert_clamp_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && acc_o == ACC_MAX && !prod_i[PROD_W-1]) |=> acc_o == ACC_MAX);
  assert_clamp_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && acc_o == ACC_MIN && prod_i[PROD_W-1]) |=> acc_o == ACC_MIN);
endmodule

// File: rtl/mac_outsat.sv
module mac_outsat #(
  parameter int unsigned ACC_W = sat_mac_pkg::ACC_W,
  parameter int unsigned RES_W = sat_mac_pkg::RES_W,
  localparam int unsigned HI_W = ACC_W - RES_W + 1
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] res_o
);
  logic [HI_W-1:0] hi;

  always_comb begin
    hi = acc_i[ACC_W-1:RES_W-1];
    if ((hi == '0) || (hi == '1)) res_o = acc_i[RES_W-1:0];
    else if (acc_i[ACC_W-1])      res_o = {1'b1, {(RES_W-1){1'b0}}};
    else                          res_o = {1'b0, {(RES_W-1){1'b1}}};
  end

  always_comb begin
    if (!acc_i[ACC_W-1] && hi != '0)
      assert_pos_clip_R7: assert (res_o == {1'b0, {(RES_W-1){1'b1}}});
    if (acc_i[ACC_W-1] && hi != '1)
      assert_neg_clip_R7: assert (res_o == {1'b1, {(RES_W-1){1'b0}}});
  end
endmodule

// File: rtl/sat_mac.sv
module sat_mac #(
  parameter int unsigned OP_W  = sat_mac_pkg::OP_W,
  parameter int unsigned ACC_W = sat_mac_pkg::ACC_W,
  parameter int unsigned RES_W = sat_mac_pkg::RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             clear_i,
  input  logic             sym_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic [OP_W-1:0]  m_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [RES_W-1:0] res_o,
  output logic             ovf_o
);
  localparam int unsigned PROD_W = 2 * OP_W + 1;

  logic              p_vld, p_clr;
  logic [PROD_W-1:0] p_prod;

  mac_premul #(.OP_W(OP_W)) u_premul (
    .clk_i, .rst_ni, .valid_i, .clear_i, .sym_i, .a_i, .b_i, .m_i,
    .vld_o(p_vld), .clr_o(p_clr), .prod_o(p_prod)
  );

  mac_accum #(.ACC_W(ACC_W), .RES_W(RES_W), .PROD_W(PROD_W)) u_accum (
    .clk_i, .rst_ni, .vld_i(p_vld), .clr_i(p_clr), .prod_i(p_prod),
    .acc_o, .ovf_o
  );

  mac_outsat #(.ACC_W(ACC_W), .RES_W(RES_W)) u_outsat (
    .acc_i(acc_o), .res_o
  );
endmodule

// File: tb/sat_mac_test.sv
module sat_mac_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 0, clear = 0, sym = 0;
  logic [15:0] a = 0, b = 0, m = 0;
  logic [39:0] acc_o;
  logic [31:0] res_o;
  logic        ovf_o;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam longint MAX40 = (longint'(1) << 39) - 1;
  localparam longint MIN40 = -(longint'(1) << 39);
  localparam longint MAX32 = 64'sd2147483647;
  localparam longint MIN32 = -64'sd2147483648;

  longint acc_m = 0, pp_m = 0;
  bit     ovf_m = 0, pv_m = 0, pc_m = 0;

  always #2 clk = ~clk;

  sat_mac uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clear_i(clear), .sym_i(sym),
    .a_i(a), .b_i(b), .m_i(m), .acc_o(acc_o), .res_o(res_o), .ovf_o(ovf_o)
  );

  function automatic longint prod_f(logic [15:0] x, logic [15:0] y, logic [15:0] z, bit s);
    longint p = longint'($signed(x));
    if (s) p = p + longint'($signed(z));
    return p * longint'($signed(y));
  endfunction

  function automatic longint sat40(longint v);
    if (v > MAX40) return MAX40;
    if (v < MIN40) return MIN40;
    return v;
  endfunction

  function automatic longint sat32(longint v);
    if (v > MAX32) return MAX32;
    if (v < MIN32) return MIN32;
    return v;
  endfunction

  function automatic bit out32(longint v);
    return (v > MAX32) || (v < MIN32);
  endfunction

  task automatic check_all(string tag);
    longint r = sat32(acc_m);
    checks += 3;
    if (acc_o !== acc_m[39:0]) begin
      errors++; $display("FAIL %s acc_o actual %h expected %h", tag, acc_o, acc_m[39:0]);
    end
    if (res_o !== r[31:0]) begin
      errors++; $display("FAIL %s res_o actual %h expected %h", tag, res_o, r[31:0]);
    end
    if (ovf_o !== ovf_m) begin
      errors++; $display("FAIL %s ovf_o actual %b expected %b", tag, ovf_o, ovf_m);
    end
  endtask

  task automatic cyc(bit v, bit c, bit s, logic [15:0] ia, logic [15:0] ib,
                     logic [15:0] im, string tag);
    valid = v; clear = c; sym = s; a = ia; b = ib; m = im;
    @(posedge clk);
    if (pv_m) begin
      acc_m = sat40((pc_m ? 0 : acc_m) + pp_m);
      ovf_m = (ovf_m & ~pc_m) | out32(acc_m);
    end
    pv_m = v; pc_m = v & c;
    if (v) pp_m = prod_f(ia, ib, im, s);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R2: issue then observe after two edges; back-to-back accumulation
    cyc(1, 1, 0, 16'd3, 16'd5, 16'd0, "R2 stage one");
    if (acc_o !== 40'd0) begin errors++; $display("FAIL R2 early acc actual %h expected 0", acc_o); end
    checks++;
    cyc(1, 0, 0, 16'hFFF9, 16'd4, 16'd0, "R2 first visible");
    if (acc_o !== 40'd15) begin errors++; $display("FAIL R2 acc actual %h expected f", acc_o); end
    checks++;
    cyc(1, 0, 0, 16'h8000, 16'h8000, 16'd0, "R3 neg times neg");
    cyc(1, 0, 0, 16'h7FFF, 16'h8000, 16'd0, "R3 mixed sign");
    cyc(0, 0, 0, 16'd0, 16'd0, 16'd0, "R3 drain");

    // R4: pre-add at the top of the range must not wrap
    cyc(1, 1, 1, 16'h7FFF, 16'h7FFF, 16'h7FFF, "R4 max pre-add");
    cyc(1, 0, 1, 16'h8000, 16'h0001, 16'h8000, "R4 min pre-add");
    cyc(0, 0, 0, 16'd0, 16'd0, 16'd0, "R4 drain");
    if (acc_o !== 40'(longint'(65534) * 32767 - 65536)) begin
      errors++; $display("FAIL R4 acc actual %h", acc_o);
    end
    checks++;

    // R9: unissued cycles with clear and junk change nothing
    repeat (3) cyc(0, 1, 1, 16'h1234, 16'h7FFF, 16'h4321, "R9 ignored");

    // R5: clear mid-stream
    cyc(1, 0, 0, 16'd100, 16'd100, 16'd0, "R5 pre");
    cyc(1, 1, 0, 16'd7, 16'hFFFE, 16'd0, "R5 load");
    cyc(0, 0, 0, 16'd0, 16'd0, 16'd0, "R5 drain");
    if (acc_o !== 40'hFF_FFFF_FFF2) begin errors++; $display("FAIL R5 acc actual %h expected fffffffff2", acc_o); end
    checks++;

    // R6/R7/R8: drive into the positive rail (each product is 2^31)
    cyc(1, 1, 1, 16'h8000, 16'h8000, 16'h8000, "R8 load out of range");
    repeat (299) cyc(1, 0, 1, 16'h8000, 16'h8000, 16'h8000, "R6 positive clamp");
    cyc(0, 0, 0, 16'd0, 16'd0, 16'd0, "R6 drain");
    if (acc_o !== MAX40[39:0] || res_o !== 32'h7FFF_FFFF) begin
      errors++; $display("FAIL R6 R7 rail actual %h %h expected %h 7fffffff", acc_o, res_o, MAX40[39:0]);
    end
    checks++;
    // come back down to in-range; flag must stay set
    repeat (256) cyc(1, 0, 1, 16'h8000, 16'h7FFF, 16'h8000, "R8 sticky");
    cyc(0, 0, 0, 16'd0, 16'd0, 16'd0, "R8 drain");
    if (ovf_o !== 1'b1) begin errors++; $display("FAIL R8 sticky actual %b expected 1", ovf_o); end
    checks++;
    cyc(1, 1, 0, 16'd2, 16'd2, 16'd0, "R8 clear");
    cyc(0, 0, 0, 16'd0, 16'd0, 16'd0, "R8 cleared");
    if (ovf_o !== 1'b0 || acc_o !== 40'd4) begin
      errors++; $display("FAIL R8 clear actual %b %h expected 0 4", ovf_o, acc_o);
    end
    checks++;
    // negative rail
    repeat (300) cyc(1, 0, 1, 16'h8000, 16'h7FFF, 16'h8000, "R6 negative clamp");
    cyc(0, 0, 0, 16'd0, 16'd0, 16'd0, "R6 neg drain");
    if (acc_o !== MIN40[39:0] || res_o !== 32'h8000_0000) begin
      errors++; $display("FAIL R6 R7 low rail actual %h %h expected %h 80000000", acc_o, res_o, MIN40[39:0]);
    end
    checks++;

    // R3 R4 R5 R9: random mix
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit c = ($urandom % 20) == 0;
      bit s = $urandom % 2;
      logic [15:0] ra = 16'($urandom);
      logic [15:0] rb = 16'($urandom);
      logic [15:0] rm = 16'($urandom);
      if (($urandom % 8) == 0) begin ra = 16'h8000; rm = 16'h8000; rb = 16'h8000; end
      cyc(v, c, s, ra, rb, rm, "R3 R4 R5 R9 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule